// File: doc/BRIEF.md
# Fault Supervisor with Hiccup Recovery

This block decides whether a switching power controller may switch. It takes digitized comparator flags: supply on and off thresholds, supply over-voltage, a hysteretic pair of over-temperature flags, the two enable-pin thresholds, a per-cycle current-limit flag and a current-sense-open flag. A cycle strobe marks the end of each switching period. From these it drives a run enable, a flag that turns the start-up current source on, and a 3-bit fault code.

The core is a six-state machine. `ST_OFF` is under-voltage lockout: the start-up source charges the supply. `ST_RUN` allows switching. `ST_OT_HOLD` pauses switching during over-temperature without a full shutdown. `ST_DRAIN` and `ST_CHARGE` form the hiccup recovery loop after a hard fault. `ST_DISABLED` is the complete shutdown commanded by the enable pin. The transitions are:
- OFF→RUN on supply above on.
- RUN→OFF on supply below off.
- RUN→OT_HOLD on high temperature.
- OT_HOLD→RUN on low temperature, and OT_HOLD→OFF on supply below off.
- RUN→DRAIN on a deglitched over-voltage, an overload streak or an open-sense streak.
- DRAIN→CHARGE on supply below off.
- CHARGE→DRAIN on supply above on while rises remain.
- CHARGE→RUN on the last rise.
- Any state→DISABLED on a deglitched enable-low.
- DISABLED→OFF on enable high.

Two deglitch filters qualify the over-voltage flag and the enable-low flag. Two streak counters count strobes: one counts consecutive current-limit cycles, the other counts consecutive open-sense cycles.

Top module: `fault_supervisor`

## Requirements
- R1: With `vdd_above_on` high, `ST_OFF` goes to run, and `run_en` rises one clock later. In run, `vdd_below_off` stops switching on the next clock and returns to lockout. Lockout reports code 1 and run reports code 0.
- R2: `vdd_ovp` high for `DEGLITCH_CYC` consecutive clocks while running stops switching and enters hiccup with code 2. A shorter pulse has no effect, and the deglitch count restarts when the flag drops.
- R3: `OLP_CYC` consecutive strobes with `cl_hit` high stop switching with code 3. A strobe with `cl_hit` low restarts the count.
- R4: `ot_high` while running stops switching with code 4, and the start-up source stays off. Switching resumes only when `ot_low` is seen. A level between the two flags keeps the pause.
- R5: `en_low` high for `DEGLITCH_CYC` clocks forces `ST_DISABLED` from any state, with run and start-up source both off and code 6. `en_high` then returns the block to lockout.
- R6: `OPEN_CYC` consecutive strobes with `cs_open` high stop switching with code 5. A strobe without it restarts the count.
- R7: After a hard fault the start-up source stays off until `vdd_below_off`, then turns on until `vdd_above_on`. Switching restarts only on the `HICCUP_N`-th such rise, and the fault code is held throughout.
- R8: `hv_src_on` is high in lockout and during hiccup charge and low elsewhere. Reset places the block in lockout (run 0, source 1, code 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_stb | input | 1 | One-clock pulse at the end of each switching cycle |
| vdd_above_on | input | 1 | Supply above start threshold |
| vdd_below_off | input | 1 | Supply below stop threshold |
| vdd_ovp | input | 1 | Supply over-voltage comparator |
| ot_high | input | 1 | Die temperature above upper trip |
| ot_low | input | 1 | Die temperature below lower release |
| en_high | input | 1 | Enable pin above upper threshold or floating |
| en_low | input | 1 | Enable pin below lower threshold |
| cl_hit | input | 1 | Current limit reached in the cycle closed by the strobe |
| cs_open | input | 1 | Current-sense open / rectifier-short indication for the cycle |
| run_en | output | 1 | Switching allowed |
| hv_src_on | output | 1 | Start-up current source on |
| fault_code | output | 3 | 0 none, 1 lockout, 2 over-voltage, 3 overload, 4 temperature, 5 sense open, 6 disabled |

## Verification
The assertions take several things for granted about the inputs. Each pair of threshold flags is treated as mutually exclusive: the supply is never both above on and below off, the die is never both hot and cool, and the enable pin is never both high and low. The current-limit and open-sense flags are taken as meaningful only in the clock where `cyc_stb` is high. The stimulus keeps every pair exclusive, and it raises `cl_hit` and `cs_open` only together with a one-clock strobe. Small parameter values keep the deglitch, overload and hiccup windows short enough to step through them exactly.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_RUN      = 3'd1,
        ST_OT_HOLD  = 3'd2,
        ST_DRAIN    = 3'd3,
        ST_CHARGE   = 3'd4,
        ST_DISABLED = 3'd5
    } fsup_state_e;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_UVLO     = 3'd1,
        FC_OVP      = 3'd2,
        FC_OLP      = 3'd3,
        FC_OTP      = 3'd4,
        FC_SENSE    = 3'd5,
        FC_DISABLED = 3'd6
    } fsup_code_e;

endpackage

// File: rtl/fsup_deglitch.sv
module fsup_deglitch #(
    parameter int unsigned HOLD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] TOP = HOLD_CYC[CW-1:0];

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!raw)       cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    assign clean = (cnt == TOP);

    AST_DG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        clean |-> $past(raw));  // R2

endmodule

// File: rtl/fsup_streak.sv
module fsup_streak #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic stb,
    input  logic hit,
    output logic trip
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = LIMIT[CW-1:0];

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!active)  cnt <= '0;
        else if (stb) begin
            if (!hit)            cnt <= '0;
            else if (cnt != TOP) cnt <= cnt + 1'b1;
        end
    end

    assign trip = (cnt == TOP);

    AST_STREAK_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> $past(stb && hit));  // R3

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned DEGLITCH_CYC = 2000,
    parameter int unsigned OLP_CYC      = 3640,
    parameter int unsigned OPEN_CYC     = 4,
    parameter int unsigned HICCUP_N     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_stb,
    input  logic       vdd_above_on,
    input  logic       vdd_below_off,
    input  logic       vdd_ovp,
    input  logic       ot_high,
    input  logic       ot_low,
    input  logic       en_high,
    input  logic       en_low,
    input  logic       cl_hit,
    input  logic       cs_open,
    output logic       run_en,
    output logic       hv_src_on,
    output logic [2:0] fault_code
);
    localparam int unsigned HW = (HICCUP_N > 1) ? $clog2(HICCUP_N) : 1;
    localparam logic [HW-1:0] HIC_LAST = HW'(HICCUP_N - 1);

    fsup_state_e   st_q, st_d;
    fsup_code_e    flt_q, flt_d;
    logic [HW-1:0] hic_q, hic_d;

    logic ovp_q, dis_q, olp_trip, open_trip, running;

    assign running = (st_q == ST_RUN);

    fsup_deglitch #(.HOLD_CYC(DEGLITCH_CYC)) u_dg_ovp (
        .clk(clk), .rst_n(rst_n), .raw(vdd_ovp), .clean(ovp_q));

    fsup_deglitch #(.HOLD_CYC(DEGLITCH_CYC)) u_dg_en (
        .clk(clk), .rst_n(rst_n), .raw(en_low), .clean(dis_q));

    fsup_streak #(.LIMIT(OLP_CYC)) u_olp (
        .clk(clk), .rst_n(rst_n), .active(running), .stb(cyc_stb),
        .hit(cl_hit), .trip(olp_trip));

    fsup_streak #(.LIMIT(OPEN_CYC)) u_open (
        .clk(clk), .rst_n(rst_n), .active(running), .stb(cyc_stb),
        .hit(cs_open), .trip(open_trip));

    // next-state logic
    always_comb begin
        st_d  = st_q;
        flt_d = flt_q;
        hic_d = hic_q;
        if (dis_q && st_q != ST_DISABLED) begin
            st_d = ST_DISABLED;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (vdd_above_on) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (ovp_q) begin
                        st_d = ST_DRAIN; flt_d = FC_OVP; hic_d = '0;
                    end else if (olp_trip) begin
                        st_d = ST_DRAIN; flt_d = FC_OLP; hic_d = '0;
                    end else if (open_trip) begin
                        st_d = ST_DRAIN; flt_d = FC_SENSE; hic_d = '0;
                    end else if (vdd_below_off) begin
                        st_d = ST_OFF;
                    end else if (ot_high) begin
                        st_d = ST_OT_HOLD;
                    end
                end
                ST_OT_HOLD: begin
                    if (vdd_below_off) st_d = ST_OFF;
                    else if (ot_low)   st_d = ST_RUN;
                end
                ST_DRAIN: begin
                    if (vdd_below_off) st_d = ST_CHARGE;
                end
                ST_CHARGE: begin
                    if (vdd_above_on) begin
                        if (hic_q == HIC_LAST) begin
                            st_d = ST_RUN;
                        end else begin
                            st_d  = ST_DRAIN;
                            hic_d = hic_q + 1'b1;
                        end
                    end
                end
                ST_DISABLED: begin
                    if (en_high && !en_low) st_d = ST_OFF;
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            flt_q <= FC_NONE;
            hic_q <= '0;
        end else begin
            st_q  <= st_d;
            flt_q <= flt_d;
            hic_q <= hic_d;
        end
    end

    // output decode
    always_comb begin
        run_en     = 1'b0;
        hv_src_on  = 1'b0;
        fault_code = FC_NONE;
        unique case (st_q)
            ST_OFF:      begin hv_src_on = 1'b1; fault_code = FC_UVLO; end
            ST_RUN:      begin run_en = 1'b1; fault_code = FC_NONE; end
            ST_OT_HOLD:  fault_code = FC_OTP;
            ST_DRAIN:    fault_code = flt_q;
            ST_CHARGE:   begin hv_src_on = 1'b1; fault_code = flt_q; end
            ST_DISABLED: fault_code = FC_DISABLED;
            default:     fault_code = FC_UVLO;
        endcase
    end

    AST_UVLO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && vdd_below_off) |=> !run_en);  // R1
    AST_RUN_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> ($past(vdd_above_on) || $past(ot_low)));  // R1
    AST_OVP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ovp_q) |=> !run_en);  // R2
    AST_OLP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && olp_trip) |=> !run_en);  // R3
    AST_OT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ot_high) |=> !run_en);  // R4
    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !en_high) |=> (!run_en && !hv_src_on));  // R5
    AST_OPEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && open_trip) |=> !run_en);  // R6
    AST_HIC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hic_q <= HIC_LAST);  // R7

endmodule

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DG = 8, OLP = 10, OPN = 4, HIC = 3;
    localparam int NSTEP = 22;

    // {req[3:0], ovp, ot_hi, ot_lo, en_low, en_high, above, below, hold[7:0], run, hv, code[2:0]}
    localparam logic [23:0] TBL [NSTEP] = '{
        {4'd1, 7'b0000101, 8'd3,  1'b0, 1'b1, 3'd1},  // R1 lockout
        {4'd1, 7'b0000110, 8'd2,  1'b1, 1'b0, 3'd0},  // R1 start
        {4'd1, 7'b0000100, 8'd2,  1'b1, 1'b0, 3'd0},  // R1 mid supply keeps run
        {4'd1, 7'b0000101, 8'd2,  1'b0, 1'b1, 3'd1},  // R1 stop
        {4'd1, 7'b0000110, 8'd2,  1'b1, 1'b0, 3'd0},  // R1 restart
        {4'd4, 7'b0100100, 8'd2,  1'b0, 1'b0, 3'd4},  // R4 hot
        {4'd4, 7'b0000100, 8'd3,  1'b0, 1'b0, 3'd4},  // R4 hysteresis band
        {4'd4, 7'b0010100, 8'd2,  1'b1, 1'b0, 3'd0},  // R4 release
        {4'd2, 7'b1000100, 8'd6,  1'b1, 1'b0, 3'd0},  // R2 short pulse ignored
        {4'd2, 7'b0000100, 8'd2,  1'b1, 1'b0, 3'd0},  // R2 count restarts
        {4'd2, 7'b1000100, 8'd12, 1'b0, 1'b0, 3'd2},  // R2 trip
        {4'd7, 7'b0000100, 8'd3,  1'b0, 1'b0, 3'd2},  // R7 drain
        {4'd7, 7'b0000101, 8'd2,  1'b0, 1'b1, 3'd2},  // R7 charge 1
        {4'd7, 7'b0000110, 8'd2,  1'b0, 1'b0, 3'd2},  // R7 rise 1
        {4'd7, 7'b0000101, 8'd2,  1'b0, 1'b1, 3'd2},  // R7 charge 2
        {4'd7, 7'b0000110, 8'd2,  1'b0, 1'b0, 3'd2},  // R7 rise 2
        {4'd7, 7'b0000101, 8'd2,  1'b0, 1'b1, 3'd2},  // R7 charge 3
        {4'd7, 7'b0000110, 8'd2,  1'b1, 1'b0, 3'd0},  // R7 rise 3 restarts
        {4'd5, 7'b0001010, 8'd5,  1'b1, 1'b0, 3'd0},  // R5 short low ignored
        {4'd5, 7'b0001010, 8'd10, 1'b0, 1'b0, 3'd6},  // R5 disabled
        {4'd5, 7'b0000110, 8'd1,  1'b0, 1'b1, 3'd1},  // R5 back to lockout
        {4'd1, 7'b0000110, 8'd1,  1'b1, 1'b0, 3'd0}   // R1 run again
    };

    logic clk = 1'b0, rst_n = 1'b0, cyc_stb = 1'b0;
    logic vdd_above_on = 1'b0, vdd_below_off = 1'b1, vdd_ovp = 1'b0;
    logic ot_high = 1'b0, ot_low = 1'b0, en_high = 1'b1, en_low = 1'b0;
    logic cl_hit = 1'b0, cs_open = 1'b0;
    logic run_en, hv_src_on;
    logic [2:0] fault_code;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fault_supervisor #(.DEGLITCH_CYC(DG), .OLP_CYC(OLP), .OPEN_CYC(OPN),
                       .HICCUP_N(HIC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb),
        .vdd_above_on(vdd_above_on), .vdd_below_off(vdd_below_off),
        .vdd_ovp(vdd_ovp), .ot_high(ot_high), .ot_low(ot_low),
        .en_high(en_high), .en_low(en_low), .cl_hit(cl_hit), .cs_open(cs_open),
        .run_en(run_en), .hv_src_on(hv_src_on), .fault_code(fault_code));

    task automatic check(input string req, input logic er, input logic eh, input logic [2:0] ec);
        n_chk++;
        if (run_en !== er || hv_src_on !== eh || fault_code !== ec) begin
            n_bad++;
            $display("FAIL %s: run/hv/code = %b/%b/%0d expected %b/%b/%0d",
                     req, run_en, hv_src_on, fault_code, er, eh, ec);
        end
    endtask

    task automatic strobe(input logic hit, input logic opn);
        @(negedge clk);
        cyc_stb = 1'b1; cl_hit = hit; cs_open = opn;
        @(negedge clk);
        cyc_stb = 1'b0; cl_hit = 1'b0; cs_open = 1'b0;
    endtask

    task automatic set_supply(input logic above, input logic below, input int n);
        vdd_above_on = above; vdd_below_off = below;
        repeat (n) @(negedge clk);
    endtask

    task automatic recover();
        for (int i = 0; i < HIC; i++) begin
            set_supply(1'b0, 1'b1, 2);
            set_supply(1'b1, 1'b0, 2);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", 1'b0, 1'b1, 3'd1);
        rst_n = 1'b1;

        for (int s = 0; s < NSTEP; s++) begin
            logic [23:0] e;
            e = TBL[s];
            {vdd_ovp, ot_high, ot_low, en_low, en_high, vdd_above_on, vdd_below_off} = e[19:13];
            repeat (int'(e[12:5])) @(negedge clk);
            check($sformatf("R%0d table step %0d", e[23:20], s), e[4], e[3], e[2:0]);
        end

        // R3 overload streak, broken then completed
        for (int i = 0; i < OLP - 1; i++) strobe(1'b1, 1'b0);
        strobe(1'b0, 1'b0);
        for (int i = 0; i < OLP - 1; i++) strobe(1'b1, 1'b0);
        check("R3 broken streak keeps run", 1'b1, 1'b0, 3'd0);
        strobe(1'b1, 1'b0);
        @(negedge clk);
        check("R3 overload trip", 1'b0, 1'b0, 3'd3);
        recover();
        check("R7 restart after overload", 1'b1, 1'b0, 3'd0);

        // R6 open-sense streak
        for (int i = 0; i < OPN - 1; i++) strobe(1'b0, 1'b1);
        strobe(1'b0, 1'b0);
        for (int i = 0; i < OPN - 1; i++) strobe(1'b0, 1'b1);
        check("R6 broken streak keeps run", 1'b1, 1'b0, 3'd0);
        strobe(1'b0, 1'b1);
        @(negedge clk);
        check("R6 open-sense trip", 1'b0, 1'b0, 3'd5);
        set_supply(1'b0, 1'b1, 2);
        check("R8 source on in charge", 1'b0, 1'b1, 3'd5);
        set_supply(1'b1, 1'b0, 2);
        set_supply(1'b0, 1'b1, 2);
        set_supply(1'b1, 1'b0, 2);
        check("R7 two rises not enough", 1'b0, 1'b0, 3'd5);
        set_supply(1'b0, 1'b1, 2);
        set_supply(1'b1, 1'b0, 2);
        check("R7 third rise restarts", 1'b1, 1'b0, 3'd0);

        // R5 disable overrides hiccup
        vdd_ovp = 1'b1;
        repeat (DG + 3) @(negedge clk);
        vdd_ovp = 1'b0;
        check("R2 trip before disable", 1'b0, 1'b0, 3'd2);
        en_high = 1'b0; en_low = 1'b1;
        repeat (DG + 3) @(negedge clk);
        check("R5 disable during hiccup", 1'b0, 1'b0, 3'd6);
        en_low = 1'b0; en_high = 1'b1;
        set_supply(1'b0, 1'b1, 3);
        check("R1 lockout after enable", 1'b0, 1'b1, 3'd1);

        // R8 reset while running
        set_supply(1'b1, 1'b0, 2);
        check("R1 run before reset", 1'b1, 1'b0, 3'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset while running", 1'b0, 1'b1, 3'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule